// File: doc/BRIEF.md
# Mux-Carry Ripple Adder with Range Flags

This block adds two k-bit operands and a carry-in with no clock. The result is a k-bit sum, a carry-out, and two range flags: one for unsigned operands and one for two's-complement operands. The adder is a chain of identical bit cells. Each cell forms a propagate bit from its two operand bits. A 2:1 multiplexer, driven by that propagate bit, then picks the outgoing carry. When propagate is high the mux forwards the incoming carry. When it is low the mux takes the y bit, which then acts as the generate term. This is how carry chains in lookup-table fabrics are built, so the netlist maps straight onto them.

There is no mode input. To subtract, the caller inverts y and drives the carry-in to 1. In that case a carry-out of 1 means no borrow was taken, and a carry-out of 0 means the unsigned difference fell below zero. The carry-out port is the unsigned range flag.

Top module: `mux_carry_adder`

## Requirements
- R1: `sum_o` equals (x + y + cin) modulo 2^WIDTH, for every WIDTH of at least 2.
- R2: `carry_o` is 1 exactly when x + y + cin exceeds 2^WIDTH − 1, the largest unsigned value.
- R3: `ovf_o` is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R4: `ovf_o` equals the carry entering the most significant cell XOR the carry leaving it.
- R5: All four pairs of (`carry_o`, `ovf_o`) occur. At WIDTH=4 the four cases are:
  - 8+8 gives (1,1)
  - 7+1 gives (0,1)
  - 15+1 gives (1,0)
  - 1+1 gives (0,0)
- R6: With y inverted and cin=1, `sum_o` equals x − y modulo 2^WIDTH. In that case `carry_o` is 1 when x ≥ y (unsigned) and 0 when the result falls below zero.
- R7: When the top bits of x and y are equal, `carry_o` equals that top bit of y, whatever the lower bits and cin are.
- R8: When every bit position propagates (x = ~y), `carry_o` equals cin, and every bit of `sum_o` equals ~cin.
- R9: All-zero inputs give a zero sum and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand; also the generate term of each cell |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top cell; unsigned range flag |
| ovf_o | output | 1 | Two's-complement range flag |

## Verification
The hardest case to reach from the ports is a carry that ripples through every cell. This needs x to be the exact bitwise complement of y. Random 16-bit operands almost never hit that. The bench therefore drives that case directly with both carry-in values. It also applies the 4-bit operand space exhaustively, with both carry-in values. That covers every pattern of carry into and out of the sign cell, and the bench confirms that all four flag pairs appear.

// File: rtl/mca_pkg.sv
package mca_pkg;
  typedef struct packed {
    logic carry;
    logic ovf;
  } range_flags_t;
endpackage

// File: rtl/mca_cell.sv
module mca_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic prop;
  logic gen;

  assign prop = x_i ^ y_i;
  assign gen  = y_i;
  // carry mux: propagate selects incoming carry, otherwise generate
  assign c_o  = prop ? c_i : gen;
  assign s_o  = prop ^ c_i;

  always_comb begin
    if (x_i == y_i)
      a_r7_kill_gives_y: assert (c_o == y_i)
        else $error("R7: equal operand bits must emit y as carry");
  end
endmodule

// File: rtl/mca_chain.sv
module mca_chain #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  if (WIDTH < 2) begin : g_bad_width
    $error("mca_chain: WIDTH must be at least 2");
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic c_in;
    logic c_out;
    logic s;
    if (i == 0) begin : g_first
      assign c_in = cin_i;
    end else begin : g_next
      assign c_in = g_bit[i-1].c_out;
    end
    mca_cell u_cell (
      .x_i (x_i[i]),
      .y_i (y_i[i]),
      .c_i (c_in),
      .s_o (s),
      .c_o (c_out)
    );
    assign sum_o[i] = s;
  end

  assign c_msb_o = g_bit[MSB].c_in;
  assign cout_o  = g_bit[MSB].c_out;

  always_comb begin
    if ((x_i ^ y_i) == {WIDTH{1'b1}})
      a_r8_full_propagate: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}})
        else $error("R8: full propagate chain mismatch");
  end
endmodule

// File: rtl/mca_flags.sv
module mca_flags
  import mca_pkg::*;
(
  input  logic         x_msb_i,
  input  logic         y_msb_i,
  input  logic         s_msb_i,
  input  logic         c_msb_i,
  input  logic         cout_i,
  output range_flags_t flags_o
);
  assign flags_o.carry = cout_i;
  assign flags_o.ovf   = c_msb_i ^ cout_i;

  always_comb begin
    a_r3_sign_rule: assert (flags_o.ovf == ((x_msb_i == y_msb_i) && (s_msb_i != x_msb_i)))
      else $error("R3: overflow disagrees with operand sign rule");
  end
endmodule

// File: rtl/mux_carry_adder.sv
module mux_carry_adder
  import mca_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic         c_msb;
  logic         cout;
  range_flags_t flags;

  mca_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i     (x_i),
    .y_i     (y_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .c_msb_o (c_msb),
    .cout_o  (cout)
  );

  mca_flags u_flags (
    .x_msb_i (x_i[MSB]),
    .y_msb_i (y_i[MSB]),
    .s_msb_i (sum_o[MSB]),
    .c_msb_i (c_msb),
    .cout_i  (cout),
    .flags_o (flags)
  );

  assign carry_o = flags.carry;
  assign ovf_o   = flags.ovf;

  always_comb begin
    a_r1_sum_total: assert ({carry_o, sum_o} ==
                            ({1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("R1/R2: sum or carry differs from arithmetic total");
  end
endmodule

// File: tb/sim_mux_carry_adder.sv
module sim_mux_carry_adder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  bit seen [4];

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        ci16 = 1'b0, c16, v16;
  logic [3:0]  a4 = '0, b4 = '0, s4;
  logic        ci4 = 1'b0, c4, v4;

  mux_carry_adder #(.WIDTH(16)) u0 (
    .x_i(a16), .y_i(b16), .cin_i(ci16), .sum_o(s16), .carry_o(c16), .ovf_o(v16));
  mux_carry_adder #(.WIDTH(4)) u1 (
    .x_i(a4), .y_i(b4), .cin_i(ci4), .sum_o(s4), .carry_o(c4), .ovf_o(v4));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run16(input logic [15:0] x, input logic [15:0] y, input logic ci);
    logic [16:0] full;
    logic [15:0] low;
    logic        vref;
    @(posedge clk);
    a16 = x; b16 = y; ci16 = ci;
    @(negedge clk);
    full = {1'b0, x} + {1'b0, y} + {16'd0, ci};
    low  = {1'b0, x[14:0]} + {1'b0, y[14:0]} + {15'd0, ci};
    vref = (x[15] == y[15]) && (full[15] != x[15]);
    chk("R1 sum16", 32'(s16), 32'(full[15:0]));
    chk("R2 carry16", 32'(c16), 32'(full[16]));
    chk("R3 ovf16", 32'(v16), 32'(vref));
    chk("R4 msb carries16", 32'(v16), 32'(low[15] ^ full[16]));
    if (x[15] == y[15]) chk("R7 kill16", 32'(c16), 32'(y[15]));
  endtask

  task automatic run4(input logic [3:0] x, input logic [3:0] y, input logic ci);
    logic [4:0] full;
    logic [3:0] low;
    logic       vref;
    @(posedge clk);
    a4 = x; b4 = y; ci4 = ci;
    @(negedge clk);
    full = {1'b0, x} + {1'b0, y} + {4'd0, ci};
    low  = {1'b0, x[2:0]} + {1'b0, y[2:0]} + {3'd0, ci};
    vref = (x[3] == y[3]) && (full[3] != x[3]);
    chk("R1 sum4", 32'(s4), 32'(full[3:0]));
    chk("R2 carry4", 32'(c4), 32'(full[4]));
    chk("R3 ovf4", 32'(v4), 32'(vref));
    chk("R4 msb carries4", 32'(v4), 32'(low[3] ^ full[4]));
    if (x[3] == y[3]) chk("R7 kill4", 32'(c4), 32'(y[3]));
    seen[{c4, v4}] = 1'b1;
  endtask

  task automatic sub16(input logic [15:0] x, input logic [15:0] y);
    run16(x, ~y, 1'b1);
    chk("R6 difference", 32'(s16), 32'(16'(x - y)));
    chk("R6 no-borrow", 32'(c16), 32'(x >= y));
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R9 idle inputs
    @(negedge clk);
    chk("R9 zero sum", 32'(s16), 32'd0);
    chk("R9 zero flags", 32'({c16, v16}), 32'd0);

    // R5 directed flag pairs
    run4(4'd8, 4'd8, 1'b0); chk("R5 C1V1", 32'({c4, v4}), 32'b11);
    run4(4'd7, 4'd1, 1'b0); chk("R5 C0V1", 32'({c4, v4}), 32'b01);
    run4(4'd15, 4'd1, 1'b0); chk("R5 C1V0", 32'({c4, v4}), 32'b10);
    run4(4'd1, 4'd1, 1'b0); chk("R5 C0V0", 32'({c4, v4}), 32'b00);

    // exhaustive 4-bit
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++)
          run4(4'(x), 4'(y), 1'(c));
    for (int k = 0; k < 4; k++) chk("R5 pair reached", 32'(seen[k]), 32'd1);

    // R8 full propagate
    run16(16'h0000, 16'hFFFF, 1'b0); chk("R8 cin0", 32'({c16, s16}), 32'h0FFFF);
    run16(16'h0000, 16'hFFFF, 1'b1); chk("R8 cin1", 32'({c16, s16}), 32'h10000);
    run16(16'hA5C3, 16'h5A3C, 1'b1); chk("R8 mixed", 32'({c16, s16}), 32'h10000);
    run4(4'b0101, 4'b1010, 1'b1); chk("R8 four", 32'({c4, s4}), 32'b10000);

    // R6 subtraction
    sub16(16'd5, 16'd3);
    sub16(16'd3, 16'd5);
    sub16(16'h8000, 16'h0001);
    sub16(16'h1234, 16'h1234);
    for (int i = 0; i < 200; i++) sub16(16'($urandom), 16'($urandom));

    // random 16-bit and extremes
    run16(16'h7FFF, 16'h0001, 1'b0);
    run16(16'h8000, 16'h8000, 1'b0);
    run16(16'hFFFF, 16'hFFFF, 1'b1);
    for (int i = 0; i < 2000; i++) run16(16'($urandom), 16'($urandom), 1'($urandom));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule